// File: doc/BRIEF.md
# Trimmed Prescaler with Square-Wave Select

This block runs from a 32.768 kHz clock and divides it down to the 256 Hz tick that drives a timekeeping core. A prescaler first produces a 4096 Hz event stream. A signed parts-per-million trim then corrects that stream. Each trim step is worth 1 ppm and the range reaches ±127 ppm. A positive trim adds an extra event now and then. A negative trim drops one. The tick and the slower square-wave rates are all derived from the corrected stream, so they follow the trim.

A second output pin carries a square wave. A 2-bit select picks its rate, and an enable bit gates it:
- select 0 gives 1 Hz, trimmed;
- select 1 gives 512 Hz, trimmed;
- select 2 gives the 4096 Hz prescaler wave, untrimmed;
- select 3 gives a free-running divide-by-8 of the input clock.

While the enable is 0, the pin stays low.

The trim controller is a two-state machine:
- `TS_RUN` is the normal state. On each prescaler event it adds the trim magnitude to an accumulator. When the sum reaches the scale (1,000,000 by default), it subtracts the scale. A negative trim then drops that event. A positive trim passes it on and takes the transition `RUN->INSERT`.
- `TS_INSERT` emits one extra corrected event in the next cycle. It then takes the transition `INSERT->RUN`.
- All other prescaler events take the transition `RUN->RUN` and pass through unchanged.

Top module: `trimmed_prescaler`

## Requirements
- R1: During reset and in the first cycle after it, `tick_256` and `sqw_out` are 0.
- R2: `tick_256` is a one-cycle pulse on every 16th corrected event. With trim 0 it repeats every 128 clock cycles.
- R3: With a positive trim t and scale S, one extra corrected event is inserted for every S/t prescaler events. The accumulator always stays below S.
- R4: With a negative trim −t, one prescaler event is dropped for every S/t prescaler events.
- R5: Select 1 (`sqw_sel` = 2'b01) gives a square wave whose period is 8 corrected events: 64 cycles at trim 0.
- R6: Select 0 (`sqw_sel` = 2'b00) gives a square wave whose period is 4096 corrected events: 32768 cycles at trim 0.
- R7: Select 2 (`sqw_sel` = 2'b10) gives a square wave with an 8-cycle period, and the trim has no effect on it.
- R8: Select 3 (`sqw_sel` = 2'b11) gives the input clock divided by 8, which is an 8-cycle period.
- R9: While `sqw_en` is 0, `sqw_out` is 0. The pin is registered, so it follows the enable one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trim_ppm | input | 8 | Signed two's-complement trim, 1 ppm per step |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_sel | input | 2 | Square-wave rate select |
| tick_256 | output | 1 | One-cycle 256 Hz tick pulse |
| sqw_out | output | 1 | Square-wave output pin |

## Verification
The assertions assume that the prescaler divides by at least two. Under that assumption a prescaler event never lands in the cycle right after another one. An inserted event therefore always comes straight after a real event, and a missing corrected event always points back to a negative trim. The stimulus changes `trim_ppm`, `sqw_sel` and `sqw_en` only on falling edges. It holds each setting across a whole measurement window and leaves a settling gap after every change. This keeps the counted edges and ticks inside the ±1 boundary tolerance. The bench lowers the scale to 1000 so that the effect of the trim shows within short windows.

// File: rtl/tpre_pkg.sv
package tpre_pkg;
    typedef enum logic [1:0] {
        SQ_ONE_HZ   = 2'd0,
        SQ_512_HZ   = 2'd1,
        SQ_4K_RAW   = 2'd2,
        SQ_CLK_DIV8 = 2'd3
    } sq_sel_e;

    typedef enum logic {
        TS_RUN    = 1'b0,
        TS_INSERT = 1'b1
    } trim_state_e;
endpackage

// File: rtl/tpre_base_div.sv
module tpre_base_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic base_evt,
    output logic raw_sq,
    output logic div8_sq
);
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;
    logic [2:0]    d8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            d8       <= '0;
            base_evt <= 1'b0;
        end else begin
            cnt      <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
            d8       <= d8 + 3'd1;
            base_evt <= (cnt == CW'(DIV - 1));
        end
    end

    assign raw_sq  = (cnt >= CW'(HALF));
    assign div8_sq = d8[2];
endmodule

// File: rtl/tpre_trim_fsm.sv
module tpre_trim_fsm
    import tpre_pkg::*;
#(
    parameter int PPM_SCALE = 1000000,
    parameter int TRIM_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_evt,
    input  logic [TRIM_W-1:0] trim,
    output logic              comp_evt
);
    localparam int ACC_W = $clog2(PPM_SCALE + (1 << TRIM_W)) + 1;

    trim_state_e       st, st_n;
    logic [ACC_W-1:0]  acc, acc_n, sum;
    logic [TRIM_W-1:0] mag;
    logic              neg, hit, evt_n;

    assign neg = trim[TRIM_W-1];
    assign mag = neg ? (~trim + 1'b1) : trim;
    assign sum = acc + ACC_W'(mag);
    assign hit = (sum >= ACC_W'(PPM_SCALE));

    always_comb begin
        st_n  = st;
        acc_n = acc;
        evt_n = 1'b0;
        unique case (st)
            TS_RUN: begin
                if (base_evt) begin
                    if (hit) begin
                        acc_n = sum - ACC_W'(PPM_SCALE);
                        if (!neg) begin
                            evt_n = 1'b1;
                            st_n  = TS_INSERT;
                        end
                    end else begin
                        acc_n = sum;
                        evt_n = 1'b1;
                    end
                end
            end
            TS_INSERT: begin
                evt_n = 1'b1;
                st_n  = TS_RUN;
            end
            default: st_n = TS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= TS_RUN;
            acc      <= '0;
            comp_evt <= 1'b0;
        end else begin
            st       <= st_n;
            acc      <= acc_n;
            comp_evt <= evt_n;
        end
    end

    assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc < ACC_W'(PPM_SCALE));

    assert_insert_after_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TS_INSERT) |-> $past(base_evt));

    assert_drop_needs_negative_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(base_evt) && !comp_evt) |-> $past(neg));
endmodule

// File: rtl/tpre_event_chain.sv
module tpre_event_chain #(
    parameter int TICK_LOG2   = 4,
    parameter int SQ_FAST_BIT = 2,
    parameter int SQ_SLOW_BIT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_evt,
    output logic tick,
    output logic sq_fast,
    output logic sq_slow
);
    localparam int CNT_W = SQ_SLOW_BIT + 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            if (comp_evt) cnt <= cnt + 1'b1;
            tick <= comp_evt && (cnt[TICK_LOG2-1:0] == '1);
        end
    end

    assign sq_fast = cnt[SQ_FAST_BIT];
    assign sq_slow = cnt[SQ_SLOW_BIT];

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/trimmed_prescaler.sv
module trimmed_prescaler
    import tpre_pkg::*;
#(
    parameter int PPM_SCALE = 1000000,
    parameter int DIV_4K    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] trim_ppm,
    input  logic       sqw_en,
    input  logic [1:0] sqw_sel,
    output logic       tick_256,
    output logic       sqw_out
);
    logic base_evt, raw_sq, div8_sq, comp_evt, sq_fast, sq_slow, sq_pick;

    tpre_base_div #(.DIV(DIV_4K)) u_div (
        .clk(clk), .rst_n(rst_n), .base_evt(base_evt),
        .raw_sq(raw_sq), .div8_sq(div8_sq)
    );

    tpre_trim_fsm #(.PPM_SCALE(PPM_SCALE), .TRIM_W(8)) u_trim (
        .clk(clk), .rst_n(rst_n), .base_evt(base_evt),
        .trim(trim_ppm), .comp_evt(comp_evt)
    );

    tpre_event_chain #(.TICK_LOG2(4), .SQ_FAST_BIT(2), .SQ_SLOW_BIT(11)) u_chain (
        .clk(clk), .rst_n(rst_n), .comp_evt(comp_evt),
        .tick(tick_256), .sq_fast(sq_fast), .sq_slow(sq_slow)
    );

    always_comb begin
        unique case (sq_sel_e'(sqw_sel))
            SQ_ONE_HZ:   sq_pick = sq_slow;
            SQ_512_HZ:   sq_pick = sq_fast;
            SQ_4K_RAW:   sq_pick = raw_sq;
            SQ_CLK_DIV8: sq_pick = div8_sq;
            default:     sq_pick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sqw_out <= 1'b0;
        else        sqw_out <= sqw_en & sq_pick;
    end

    assert_sqw_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sqw_en) |-> !sqw_out);
endmodule

// File: tb/trimmed_prescaler_test.sv
module trimmed_prescaler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] trim_ppm = 8'd0;
    logic       sqw_en = 1'b0;
    logic [1:0] sqw_sel = 2'd0;
    logic       tick_256, sqw_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trimmed_prescaler #(.PPM_SCALE(1000), .DIV_4K(8)) uut (
        .clk(clk), .rst_n(rst_n), .trim_ppm(trim_ppm), .sqw_en(sqw_en),
        .sqw_sel(sqw_sel), .tick_256(tick_256), .sqw_out(sqw_out)
    );

    typedef struct packed {
        logic [7:0]  trim;
        logic [1:0]  sel;
        logic        en;
        logic [15:0] ticks;
        logic [15:0] rises;
    } vec_t;

    // window of 6400 cycles = 800 prescaler events; scale 1000
    localparam int WIN = 6400;
    localparam vec_t VECS [7] = '{
        '{8'd0,   2'd1, 1'b1, 16'd50, 16'd100},  // R2 R5
        '{8'd100, 2'd1, 1'b1, 16'd55, 16'd110},  // R3 R5
        '{8'd156, 2'd1, 1'b1, 16'd45, 16'd90},   // R4 (-100)
        '{8'd100, 2'd2, 1'b1, 16'd55, 16'd800},  // R7 trim ignored
        '{8'd156, 2'd3, 1'b1, 16'd45, 16'd800},  // R8
        '{8'd0,   2'd2, 1'b0, 16'd50, 16'd0},    // R9
        '{8'd156, 2'd0, 1'b0, 16'd45, 16'd0}     // R9
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit near(input int a, input int e);
        return (a >= e - 1) && (a <= e + 1);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t0, t1, highs;
        // R1 reset state
        repeat (4) @(negedge clk);
        check(tick_256 == 0 && sqw_out == 0, "R1 in reset", {tick_256, sqw_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick_256 == 0 && sqw_out == 0, "R1 after reset", {tick_256, sqw_out}, 0);

        // table walk: R2..R9
        for (int v = 0; v < 7; v++) begin
            int nt, nr;
            bit prev;
            trim_ppm = VECS[v].trim;
            sqw_sel  = VECS[v].sel;
            sqw_en   = VECS[v].en;
            repeat (16) @(negedge clk);
            nt = 0; nr = 0; highs = 0; prev = sqw_out;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                if (tick_256) nt++;
                if (sqw_out && !prev) nr++;
                if (sqw_out) highs++;
                prev = sqw_out;
            end
            check(near(nt, int'(VECS[v].ticks)), $sformatf("R3/R4 ticks vec%0d", v), nt, int'(VECS[v].ticks));
            if (VECS[v].rises == 0)
                check(highs == 0, $sformatf("R9 sqw low vec%0d", v), highs, 0);
            else
                check(near(nr, int'(VECS[v].rises)), $sformatf("R5/R7/R8 rises vec%0d", v), nr, int'(VECS[v].rises));
        end

        // R2 exact tick spacing and width at trim 0
        trim_ppm = 8'd0;
        sqw_en = 1'b1;
        sqw_sel = 2'd0;
        repeat (16) @(negedge clk);
        t0 = 0;
        while (!tick_256) begin @(negedge clk); t0++; end
        @(negedge clk);
        check(tick_256 == 0, "R2 tick width", tick_256, 0);
        t1 = 1;
        while (!tick_256) begin @(negedge clk); t1++; end
        check(t1 == 128, "R2 tick period", t1, 128);

        // R6 1 Hz period at trim 0
        while (sqw_out) @(negedge clk);
        while (!sqw_out) @(negedge clk);
        t1 = 0;
        while (sqw_out) begin @(negedge clk); t1++; end
        while (!sqw_out) begin @(negedge clk); t1++; end
        check(t1 == 32768, "R6 one hz period", t1, 32768);

        // R9 enable drop reaches pin after one cycle
        sqw_sel = 2'd3;
        repeat (3) @(negedge clk);
        sqw_en = 1'b0;
        @(negedge clk);
        check(sqw_out == 0, "R9 disable latency", sqw_out, 0);

        // R1 reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check(tick_256 == 0 && sqw_out == 0, "R1 re-reset", {tick_256, sqw_out}, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule